// File: doc/BRIEF.md
# Line-Atomic VBI Byte Queue with Fill Interrupt

This block buffers sliced vertical-blanking data between a slicer and a host register port. The slicer delivers each data line as a burst of bytes on a valid/ready stream. The first beat of a line carries the declared line length. The host pulls bytes out one per read strobe. A line is admitted only when the whole declared length fits in the free space at its first beat; otherwise every byte of it is discarded and a sticky overflow flag is raised. Admitted bytes become visible to the reader, and count towards the fill level, only once the line's last beat has arrived. A line is therefore never seen half-written.

The fill level is reported in 16-bit words, which is the stored byte count halved and rounded down. A programmable 8-bit word threshold raises a sticky status bit while the level is strictly above it. The two status bits have a mask register, an interrupt line, and a write-one-to-clear register. Writing any value to the flush selector empties the queue and abandons a line in progress. Configuration writes use a 2-bit selector and an 8-bit data byte. The depth must be a power of two.

The stream applies back-pressure only in the cycle of a flush write. In that cycle `in_ready` is low and the beat offered is not taken. In every other cycle `in_ready` is high. A line that is refused for lack of space is absorbed and dropped, not stalled.

Top module: `vbi_fifo_top`

## Requirements
- R1: Bytes are returned in the order they were accepted. The byte for a `host_rd` pulse appears on `host_rdata` from the cycle after the pulse and is held until the next pulse.
- R2: `level_words` equals the committed byte count divided by two, rounded down. The bytes of a line are committed at the clock edge that takes its last beat (`in_last`=1), and not before.
- R3: At a first beat (`in_first`=1) the line is admitted if `in_len` is not more than DEPTH minus the committed count before that edge. Otherwise no byte of the line is stored. A line that fills the queue exactly is admitted.
- R4: Status bit 0 (threshold) is set at the edge after a cycle in which `level_words` is strictly greater than the threshold. The threshold is written with selector 0 and is 80h after reset. The bit is sticky.
- R5: Status bit 1 (overflow) is set at the edge that refuses a line. It stays set until it is cleared.
- R6: A write with selector 2 clears each status bit whose data bit is 1, unless that bit's condition is present in the same cycle. Data bits at 0 leave the status unchanged.
- R7: The mask is written with selector 1 (data bits 1:0) and is 00h after reset. `irq_masked` is `irq_raw` AND the mask, and `irq` is high when any masked bit is set.
- R8: A write with selector 3 and any data empties the queue, so that `level_words` is 0 the cycle after. It discards a line in progress, including that line's remaining beats, and leaves the status bits as they were. `in_ready` is low during that write.
- R9: A read strobe while no byte is committed returns 00h and leaves the level unchanged.
- R10: Beats of an admitted line beyond its declared length are discarded. The line still ends at its `in_last` beat.
- R11: After reset `level_words`, `irq_raw`, `irq_masked` and `irq` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Stream beat accepted; low only during a flush write |
| in_data | input | DW | Data byte of the beat |
| in_first | input | 1 | Beat is the first of a line |
| in_last | input | 1 | Beat is the last of a line |
| in_len | input | AW+1 | Declared line length in bytes, sampled on the first beat |
| host_rd | input | 1 | Host read strobe, one byte per pulse |
| host_rdata | output | DW | Byte returned by the last read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 threshold, 1 mask, 2 clear, 3 flush |
| cfg_wdata | input | 8 | Configuration write data |
| level_words | output | AW | Committed fill in 2-byte words |
| irq_raw | output | 2 | Sticky status: bit 0 threshold, bit 1 overflow |
| irq_masked | output | 2 | Status ANDed with the mask |
| irq | output | 1 | Any masked status bit set |

## Verification
The properties assume that no stream beat is offered in the same cycle as a flush write, and that a new line starts only after the previous line's last beat. The stimulus never overlaps a flush with a beat or a read, always closes a line with `in_last`, and declares non-zero lengths. The per-cycle model still follows the stated rule for an early or oversized line, so the length-trimming case stays inside these assumptions.

// File: rtl/vbi_fifo_pkg.sv
package vbi_fifo_pkg;
  typedef enum logic [1:0] {
    SEL_THRESH = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_FLUSH  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ADM_IDLE = 2'd0,
    ADM_TAKE = 2'd1,
    ADM_DROP = 2'd2
  } adm_state_e;

  localparam int N_IRQ   = 2;
  localparam int IRQ_THR = 0;
  localparam int IRQ_OVF = 1;
endpackage

// File: rtl/vbi_line_admit.sv
module vbi_line_admit
  import vbi_fifo_pkg::*;
#(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          first,
  input  logic          last,
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] free_bytes,
  input  logic          flush,
  output logic          st_start,
  output logic          st_wr,
  output logic          st_commit,
  output logic          reject
);
  adm_state_e    state_q;
  logic [LW-1:0] rem_q;
  logic          fits, take;
  logic [LW-1:0] cap;

  always_comb begin
    fits = (len <= free_bytes);
    if (first) begin
      take = fits;
      cap  = len;
    end else begin
      take = (state_q == ADM_TAKE);
      cap  = rem_q;
    end
    st_start  = beat && first;
    st_wr     = beat && take && (cap != '0);
    st_commit = beat && take && last;
    reject    = beat && first && !fits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ADM_IDLE;
      rem_q   <= '0;
    end else if (flush) begin
      if (state_q == ADM_TAKE) state_q <= ADM_DROP;
    end else if (beat) begin
      if (first) begin
        rem_q   <= (fits && len != '0) ? len - 1'b1 : '0;
        state_q <= last ? ADM_IDLE : (fits ? ADM_TAKE : ADM_DROP);
      end else if (state_q != ADM_IDLE) begin
        if (take && rem_q != '0) rem_q <= rem_q - 1'b1;
        if (last) state_q <= ADM_IDLE;
      end
    end
  end
endmodule

// File: rtl/vbi_byte_store.sv
module vbi_byte_store #(
  parameter  int DEPTH = 512,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_start,
  input  logic          st_wr,
  input  logic          st_commit,
  input  logic [DW-1:0] wr_byte,
  input  logic          pop_req,
  input  logic          flush,
  output logic [LW-1:0] count,
  output logic [LW-1:0] free_bytes,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head_q, tail_q, wptr_q;
  logic [LW-1:0] pend_q, count_q;
  logic [DW-1:0] rdata_q;

  logic [AW-1:0] base_ptr, wptr_nx;
  logic [LW-1:0] base_pend, pend_nx;
  logic          pop;

  always_comb begin
    base_ptr   = st_start ? tail_q : wptr_q;
    base_pend  = st_start ? '0 : pend_q;
    wptr_nx    = base_ptr + AW'(st_wr);
    pend_nx    = base_pend + LW'(st_wr);
    pop        = pop_req && (count_q != '0);
    free_bytes = LW'(DEPTH) - count_q;
  end

  always_ff @(posedge clk) begin
    if (st_wr) mem[base_ptr] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      wptr_q  <= '0;
      pend_q  <= '0;
      count_q <= '0;
      rdata_q <= '0;
    end else begin
      if (pop_req) rdata_q <= pop ? mem[head_q] : '0;
      if (flush) begin
        head_q  <= '0;
        tail_q  <= '0;
        wptr_q  <= '0;
        pend_q  <= '0;
        count_q <= '0;
      end else begin
        head_q <= head_q + AW'(pop);
        wptr_q <= wptr_nx;
        if (st_commit) begin
          tail_q  <= wptr_nx;
          pend_q  <= '0;
          count_q <= count_q - LW'(pop) + pend_nx;
        end else begin
          pend_q  <= pend_nx;
          count_q <= count_q - LW'(pop);
        end
      end
    end
  end

  assign count   = count_q;
  assign rd_data = rdata_q;
endmodule

// File: rtl/vbi_irq_ctrl.sv
module vbi_irq_ctrl
  import vbi_fifo_pkg::*;
#(
  parameter  int             LW        = 10,
  parameter  int             THR_W     = 8,
  parameter  logic [THR_W-1:0] THR_RESET = 8'h80,
  localparam int             WW        = LW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [THR_W-1:0] cfg_wdata,
  input  logic [LW-1:0]    count,
  input  logic             ovf_evt,
  output logic [WW-1:0]    words,
  output logic [THR_W-1:0] thresh,
  output logic [N_IRQ-1:0] raw,
  output logic [N_IRQ-1:0] masked,
  output logic             irq
);
  cfg_sel_e         sel;
  logic [THR_W-1:0] thresh_q;
  logic [N_IRQ-1:0] mask_q, raw_q, raw_nx, set_vec, clr_vec;

  always_comb begin
    sel              = cfg_sel_e'(cfg_sel);
    clr_vec          = (cfg_we && sel == SEL_CLEAR) ? cfg_wdata[N_IRQ-1:0] : '0;
    set_vec          = '0;
    set_vec[IRQ_THR] = count > LW'({thresh_q, 1'b1});
    set_vec[IRQ_OVF] = ovf_evt;
  end

  for (genvar b = 0; b < N_IRQ; b++) begin : g_stat
    assign raw_nx[b] = (raw_q[b] & ~clr_vec[b]) | set_vec[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thresh_q <= THR_RESET;
      mask_q   <= '0;
      raw_q    <= '0;
    end else begin
      raw_q <= raw_nx;
      if (cfg_we && sel == SEL_THRESH) thresh_q <= cfg_wdata;
      if (cfg_we && sel == SEL_MASK)   mask_q   <= cfg_wdata[N_IRQ-1:0];
    end
  end

  assign words  = WW'(count >> 1);
  assign thresh = thresh_q;
  assign raw    = raw_q;
  assign masked = raw_q & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/vbi_fifo_top.sv
module vbi_fifo_top
  import vbi_fifo_pkg::*;
#(
  parameter  int         DEPTH     = 512,
  parameter  int         DW        = 8,
  parameter  logic [7:0] THR_RESET = 8'h80,
  localparam int         AW        = $clog2(DEPTH),
  localparam int         LW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [LW-1:0] in_len,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [7:0]    cfg_wdata,
  output logic [AW-1:0] level_words,
  output logic [1:0]    irq_raw,
  output logic [1:0]    irq_masked,
  output logic          irq
);
  logic          flush_req, beat;
  logic          st_start, st_wr, st_commit, reject;
  logic [LW-1:0] byte_count, free_bytes;
  logic [7:0]    thresh_q;

  assign flush_req = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_FLUSH);
  assign in_ready  = !flush_req;
  assign beat      = in_valid && in_ready;

  vbi_line_admit #(.LW(LW)) u_admit (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .first      (in_first),
    .last       (in_last),
    .len        (in_len),
    .free_bytes (free_bytes),
    .flush      (flush_req),
    .st_start   (st_start),
    .st_wr      (st_wr),
    .st_commit  (st_commit),
    .reject     (reject)
  );

  vbi_byte_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_start   (st_start),
    .st_wr      (st_wr),
    .st_commit  (st_commit),
    .wr_byte    (in_data),
    .pop_req    (host_rd),
    .flush      (flush_req),
    .count      (byte_count),
    .free_bytes (free_bytes),
    .rd_data    (host_rdata)
  );

  vbi_irq_ctrl #(.LW(LW), .THR_W(8), .THR_RESET(THR_RESET)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .count     (byte_count),
    .ovf_evt   (reject),
    .words     (level_words),
    .thresh    (thresh_q),
    .raw       (irq_raw),
    .masked    (irq_masked),
    .irq       (irq)
  );
endmodule

// File: rtl/vbi_fifo_chk.sv
module vbi_fifo_chk #(
  parameter  int DEPTH = 512,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_rd,
  input logic [DW-1:0] host_rdata,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic          clr_ovf_bit,
  input logic [AW-1:0] level_words,
  input logic [1:0]    irq_raw,
  input logic [LW-1:0] byte_count,
  input logic [7:0]    thresh
);
  // R3: the committed fill never exceeds the capacity
  assert_level_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_words) <= DEPTH / 2);

  // R9: reading with nothing committed yields a zero byte
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && byte_count == '0) |=> (host_rdata == '0));

  // R8: a flush write leaves the level at zero
  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3) |=> (level_words == '0));

  // R5: the overflow bit holds unless a clear write targets it
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raw[1] && !(cfg_we && cfg_sel == 2'd2 && clr_ovf_bit)) |=> irq_raw[1]);

  // R4: the threshold bit only rises after the level exceeded the threshold
  assert_thresh_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_raw[0]) |-> (int'($past(level_words)) > int'($past(thresh))));

  // R2: without a flush the byte count drops by at most one per cycle
  assert_drain_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_sel == 2'd3) |=> (int'(byte_count) + 1 >= int'($past(byte_count))));
endmodule

bind vbi_fifo_top vbi_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_rd     (host_rd),
  .host_rdata  (host_rdata),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .clr_ovf_bit (cfg_wdata[1]),
  .level_words (level_words),
  .irq_raw     (irq_raw),
  .byte_count  (byte_count),
  .thresh      (thresh_q)
);

// File: tb/tb_vbi_fifo_top.sv
module tb_vbi_fifo_top;
  localparam int DEPTH = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic [9:0] in_len = '0;
  logic       host_rd = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic       in_ready, irq;
  logic [7:0] host_rdata;
  logic [8:0] level_words;
  logic [1:0] irq_raw, irq_masked;

  int checks = 0, fails = 0, cycles = 0;

  vbi_fifo_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last), .in_len(in_len),
    .host_rd(host_rd), .host_rdata(host_rdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .level_words(level_words), .irq_raw(irq_raw),
    .irq_masked(irq_masked), .irq(irq)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  byte unsigned q[$], sq[$];
  int m_state = 0, m_rem = 0, m_thr = 128, m_mask = 0, m_raw = 0, m_rd = 0;

  always @(posedge clk) begin : model
    int pre, clr;
    bit thit, ovf, fl, bt;
    if (!rst_n) begin
      q.delete(); sq.delete();
      m_state = 0; m_rem = 0; m_thr = 128; m_mask = 0; m_raw = 0; m_rd = 0;
    end else begin
      pre  = q.size();
      thit = (pre / 2) > m_thr;
      ovf  = 0;
      clr  = 0;
      fl   = cfg_we && cfg_sel == 2'd3;
      bt   = in_valid && !fl;
      if (host_rd) m_rd = (pre > 0) ? int'(q.pop_front()) : 0;
      if (bt) begin
        if (in_first) begin
          sq.delete();
          if (int'(in_len) <= DEPTH - pre) begin
            m_rem = in_len;
            if (m_rem > 0) begin sq.push_back(in_data); m_rem--; end
            if (in_last) begin
              foreach (sq[i]) q.push_back(sq[i]);
              sq.delete(); m_state = 0;
            end else m_state = 1;
          end else begin
            ovf = 1;
            m_state = in_last ? 0 : 2;
          end
        end else if (m_state == 1) begin
          if (m_rem > 0) begin sq.push_back(in_data); m_rem--; end
          if (in_last) begin
            foreach (sq[i]) q.push_back(sq[i]);
            sq.delete(); m_state = 0;
          end
        end else if (m_state == 2 && in_last) m_state = 0;
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_thr = cfg_wdata;
          2'd1: m_mask = cfg_wdata & 8'h3;
          2'd2: clr = cfg_wdata & 8'h3;
          default: begin
            q.delete(); sq.delete();
            if (m_state == 1) m_state = 2;
          end
        endcase
      end
      m_raw = (m_raw & ~clr) | (int'(ovf) << 1) | int'(thit);
    end
  end

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cmp("R1 host_rdata", host_rdata, m_rd);
      cmp("R2 level_words", level_words, q.size() / 2);
      cmp("R4/R5 irq_raw", irq_raw, m_raw);
      cmp("R7 irq_masked", irq_masked, m_raw & m_mask);
      cmp("R7 irq", irq, (m_raw & m_mask) != 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic beat(bit f, bit l, int len, int d);
    in_valid = 1; in_first = f; in_last = l; in_len = 10'(len); in_data = 8'(d);
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  task automatic line(int len, int nbeats, int base);
    for (int i = 0; i < nbeats; i++) beat(i == 0, i == nbeats - 1, len, base + i);
  endtask

  task automatic cfg(int sel, int d);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd();
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R11 reset state
    cmp("R11 level", level_words, 0);
    cmp("R11 raw", irq_raw, 0);
    cmp("R11 masked", irq_masked, 0);
    cmp("R11 irq", irq, 0);
    cmp("R11 in_ready", in_ready, 1);

    // R9 empty read
    rd();
    cmp("R9 empty rdata", host_rdata, 0);
    cmp("R9 empty level", level_words, 0);

    // R2 commit at last beat, R1 order
    for (int i = 0; i < 5; i++) beat(i == 0, 0, 6, 8'h10 + i);
    cmp("R2 before last", level_words, 0);
    beat(0, 1, 6, 8'h15);
    cmp("R2 after last", level_words, 3);
    for (int i = 0; i < 6; i++) begin
      rd();
      cmp("R1 order", host_rdata, 8'h10 + i);
    end
    cmp("R2 drained", level_words, 0);

    // R2 odd length rounds down
    line(5, 5, 8'h20);
    cmp("R2 odd level", level_words, 2);
    repeat (5) rd();

    // R10 beats beyond declared length dropped
    line(3, 5, 8'h30);
    cmp("R10 level", level_words, 1);
    for (int i = 0; i < 3; i++) begin
      rd();
      cmp("R10 kept byte", host_rdata, 8'h30 + i);
    end
    rd();
    cmp("R10 no extra byte", host_rdata, 0);

    // R4 threshold, R7 mask, R6 clear
    cfg(0, 2);
    line(8, 8, 8'h40);
    cmp("R4 not yet", irq_raw & 1, 0);
    idle(1);
    cmp("R4 raised", irq_raw & 1, 1);
    cmp("R7 masked off", irq, 0);
    cfg(1, 3);
    cmp("R7 masked on", irq_masked, 1);
    cmp("R7 irq on", irq, 1);
    cfg(2, 1);
    cmp("R6 clear while hit", irq_raw & 1, 1);
    repeat (4) rd();
    idle(1);
    cmp("R4 sticky", irq_raw & 1, 1);
    cfg(2, 1);
    cmp("R6 cleared", irq_raw & 1, 0);
    repeat (4) rd();

    // R3 admission and R5 overflow
    cfg(0, 200);
    for (int k = 0; k < 5; k++) line(100, 100, k);
    cmp("R3 filled", level_words, 250);
    line(20, 20, 8'h80);
    cmp("R3 refused", level_words, 250);
    cmp("R5 overflow", (irq_raw >> 1) & 1, 1);
    line(12, 12, 8'h90);
    cmp("R3 exact fit", level_words, 256);
    cfg(2, 0);
    cmp("R6 zero clear", (irq_raw >> 1) & 1, 1);

    // R8 flush
    cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 8'h5A;
    #1 cmp("R8 ready low", in_ready, 0);
    @(negedge clk);
    cfg_we = 0;
    cmp("R8 emptied", level_words, 0);
    cmp("R8 status kept", (irq_raw >> 1) & 1, 1);
    beat(1, 0, 4, 1);
    beat(0, 0, 4, 2);
    cfg(3, 0);
    beat(0, 0, 4, 3);
    beat(0, 1, 4, 4);
    cmp("R8 line abandoned", level_words, 0);
    rd();
    cmp("R9 read after flush", host_rdata, 0);

    cfg(2, 3);
    cmp("R6 both cleared", irq_raw, 0);
    idle(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule